// File: doc/BRIEF.md
# Extension-Field Address Unit

This block sits beside the main datapath of a 16-bit DSP core. It decodes the low byte of each instruction word, the extension field, and turns it into the side work that runs next to the main operation. That side work covers pointer stepping, register copies, single loads and stores, a combined load-plus-store, and a double load. The program counter is never touched. The unit owns four 16-bit address pointers, P0 to P3, and reads four signed step values (one per pointer) and four accumulator sub-words as inputs.

Memory requests are issued in the same cycle as the instruction. Reads are combinational: the memory answers on `rd_a_data` and `rd_b_data` within that cycle. Register results are not written here. They leave the block one cycle later as up to four ordered write requests, for a separate merge stage that combines them with the main operation's results. Pointer arithmetic uses a simple per-pointer wrap mask in place of full circular-buffer logic. The double load models a page rule: when both read pointers fall in the same 1K-word page, both destinations receive the first read's data.

Top module: `ext_addr_unit`

## Requirements
- R1: While reset is held across a clock edge, all pointers become 0 and no write request is valid.
- R2: In a cycle with `ins_valid` low, no memory enable is raised. In the following cycle no write request is valid and the pointers hold their values.
- R3: Codes `0000_01pp`, `0000_10pp` and `0000_11pp` step pointer Ppp by -1, by +1, or by its signed step value. Codes `0000_00xx` change nothing and emit no request.
- R4: A pointer update is new = (old & ~M) | ((old + delta) & M) modulo 2^16, where M is that pointer's 16-bit field of `WRAP_MASKS` (P0 in bits 15:0).
- R5: Code `0001_ddss` emits one request that writes accumulator sub-word ss into register id dd. The sub-word order on `acc_vals` is low0, low1, mid0, mid1, each 16 bits, starting from bit 0.
- R6: Code `001s_snpp` stores sub-word ss at the address in Ppp. Ppp then steps by +1, or by its step value when n=1. One request carries the new pointer.
- R7: Code `01dd_dnpp` reads at Ppp and writes the data to id ddd (0 to 7). Ppp steps as in R6. The requests are the data write, then the pointer.
- R8: With `wide_mode` set and ddd equal to 6 or 7, R7 instead emits four requests in this order: the high word (id 8 + ddd - 6) set to 0xFFFF or 0x0000 according to bit 15 of the data; the data itself; the low word (id 4 + ddd - 6) cleared; then the pointer.
- R9: Code `10dd_mnLs` reads into id dd and stores mid sub-word s. With L=0 the read uses P0 and the store uses P3; with L=1 the two are swapped. P0 steps by its step value if n=1, otherwise by +1. P3 steps by its step value if m=1, otherwise by +1. The requests are data, P3, P0.
- R10: Code `11dr_mnpp` reads twice; read b uses P3. If pp is not 3, read a uses Ppp, its data goes to id 2d and read b's data goes to id 2r+1. If pp is 3, read a uses Pd, its data goes to id 2+r and read b's data goes to id r. The first pointer steps per n and P3 steps per m. The requests are a, b, first pointer, P3.
- R11: In R10, if bits 15:10 of the two read addresses match, read b is issued at read a's address.
- R12: Requests appear the cycle after the instruction, packed from slot 0. Slot i occupies `wb_id[4i+3:4i]` and `wb_dat[16i+15:16i]`. The ids are: 0 to 7 for the eight load targets (0 x-low0, 1 x-low1, 2 x-high0, 3 x-high1, 4 low0, 5 low1, 6 mid0, 7 mid1), 8 and 9 for high0 and high1, and 12+k for Pk. All addresses use pointer values from before the instruction. Updated pointers show on `ptr_vals` in the same cycle as the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Extension field is valid this cycle |
| ins_ext | input | 8 | Extension field (instruction bits 7:0) |
| wide_mode | input | 1 | 40-bit accumulator mode |
| idx_vals | input | 64 | Signed step values for P0..P3, 16 bits each |
| acc_vals | input | 64 | Accumulator sub-words low0, low1, mid0, mid1 |
| rd_a_en | output | 1 | Read port a enable |
| rd_a_addr | output | 16 | Read port a address |
| rd_a_data | input | 16 | Read port a data, same cycle |
| rd_b_en | output | 1 | Read port b enable |
| rd_b_addr | output | 16 | Read port b address |
| rd_b_data | input | 16 | Read port b data, same cycle |
| st_en | output | 1 | Store enable |
| st_addr | output | 16 | Store address |
| st_data | output | 16 | Store data |
| wb_vld | output | 4 | Write request valid per slot |
| wb_id | output | 16 | Write request register ids, 4 bits per slot |
| wb_dat | output | 64 | Write request data, 16 bits per slot |
| ptr_vals | output | 64 | Current pointers P0..P3 |

## Verification
The bench runs every one of the 256 extension codes in both accumulator modes, under three pointer and step-value sets. One set places P0, P1 and P3 in a shared page, one keeps them in separate pages, and one sits at the 0xFFFF/0x0000 boundary. A unit that ignored the page rule would read the wrong word into the second destination. A unit that confused the swap bit would read and store through the wrong pointers. A unit that missed the wide-mode sign fill would emit two requests where four are due, or carry the wrong high word. P2 runs with a 4-bit wrap mask, and its steps pass through 0xF to 0 and from 0 to 0xF, so any carry leaking above the mask shows up in `ptr_vals`. Every check compares the requests in the cycle after issue, so a unit that read post-update pointers or put the slots in another order produces a different word.

// File: rtl/ext_pkg.sv
package ext_pkg;
    // Datapath and request geometry
    localparam int unsigned WORD_W = 16;
    localparam int unsigned PTR_N  = 4;
    localparam int unsigned ACC_N  = 4;
    localparam int unsigned SLOT_N = 4;
    localparam int unsigned RID_W  = 4;
    localparam int unsigned CODE_W = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RID_W-1:0]  rid_t;

    // Register ids seen by the merge stage
    localparam rid_t RID_LOW0  = 4'd4;
    localparam rid_t RID_HIGH0 = 4'd8;
    localparam rid_t RID_PTR0  = 4'd12;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_UP,
        STEP_DOWN,
        STEP_INDEX
    } step_e;

    typedef enum logic [2:0] {
        OPC_NONE,
        OPC_PTR,
        OPC_MOVE,
        OPC_STORE,
        OPC_LOAD,
        OPC_PAIR,
        OPC_DUAL
    } opc_e;

    typedef struct packed {
        opc_e       opc;
        logic [1:0] ptr;    // pointer used (first read pointer for the double load)
        logic [2:0] dst;    // destination id for move, load, pair
        logic [1:0] src;    // accumulator sub-word index
        logic       swap;   // pair form: read through P3, store through P0
        logic       via3;   // double load with pointer field 3
        logic       d_sel;
        logic       r_sel;
    } dec_t;
endpackage

// File: rtl/ext_decode.sv
// Extension-field decoder.
// Classifies the 8-bit field into an operation class, extracts the fields
// and states how each pointer must step. Assumes the field is only
// meaningful while valid_i is high; otherwise it yields no operation.
module ext_decode
    import ext_pkg::*;
(
    input  logic                  valid_i,
    input  logic [CODE_W-1:0]     code_i,
    output dec_t                  dec_o,
    output step_e [PTR_N-1:0]     step_o
);
    // Decode the field and derive per-pointer step kinds
    always_comb begin
        step_e      nstep;
        step_e      mstep;
        logic [1:0] first;
        nstep  = code_i[2] ? STEP_INDEX : STEP_UP;
        mstep  = code_i[3] ? STEP_INDEX : STEP_UP;
        first  = (code_i[1:0] != 2'd3) ? code_i[1:0] : {1'b0, code_i[5]};
        dec_o  = '0;
        dec_o.opc = OPC_NONE;
        for (int i = 0; i < PTR_N; i++) begin
            step_o[i] = STEP_HOLD;
        end
        if (valid_i) begin
            casez (code_i)
                8'b0000_00??: dec_o.opc = OPC_NONE;
                8'b0000_????: begin
                    dec_o.opc = OPC_PTR;
                    dec_o.ptr = code_i[1:0];
                    case (code_i[3:2])
                        2'b01:   step_o[code_i[1:0]] = STEP_DOWN;
                        2'b10:   step_o[code_i[1:0]] = STEP_UP;
                        default: step_o[code_i[1:0]] = STEP_INDEX;
                    endcase
                end
                8'b0001_????: begin
                    dec_o.opc = OPC_MOVE;
                    dec_o.dst = {1'b0, code_i[3:2]};
                    dec_o.src = code_i[1:0];
                end
                8'b001?_????: begin
                    dec_o.opc = OPC_STORE;
                    dec_o.ptr = code_i[1:0];
                    dec_o.src = code_i[4:3];
                    step_o[code_i[1:0]] = nstep;
                end
                8'b01??_????: begin
                    dec_o.opc = OPC_LOAD;
                    dec_o.ptr = code_i[1:0];
                    dec_o.dst = code_i[5:3];
                    step_o[code_i[1:0]] = nstep;
                end
                8'b10??_????: begin
                    dec_o.opc  = OPC_PAIR;
                    dec_o.dst  = {1'b0, code_i[5:4]};
                    dec_o.src  = {1'b1, code_i[0]};
                    dec_o.swap = code_i[1];
                    step_o[0]  = nstep;
                    step_o[3]  = mstep;
                end
                default: begin
                    dec_o.opc   = OPC_DUAL;
                    dec_o.ptr   = first;
                    dec_o.via3  = (code_i[1:0] == 2'd3);
                    dec_o.d_sel = code_i[5];
                    dec_o.r_sel = code_i[4];
                    step_o[first] = nstep;
                    step_o[3]     = mstep;
                end
            endcase
        end
    end
endmodule

// File: rtl/ext_step.sv
// Single pointer stepper.
// Adds +1, -1 or a signed step value to a pointer and keeps only the bits
// selected by MASK; bits outside the mask keep their old value. Modulo 2^16.
module ext_step
    import ext_pkg::*;
#(
    parameter word_t MASK = '1
)
(
    input  word_t cur_i,
    input  word_t idx_i,
    input  step_e kind_i,
    output word_t nxt_o
);
    word_t delta;
    word_t sum;

    // Pick the increment for this pointer
    always_comb begin
        case (kind_i)
            STEP_UP:    delta = word_t'(1);
            STEP_DOWN:  delta = '1;
            STEP_INDEX: delta = idx_i;
            default:    delta = '0;
        endcase
    end

    // Masked add: carries past the mask are dropped
    always_comb begin
        sum   = cur_i + delta;
        nxt_o = (cur_i & ~MASK) | (sum & MASK);
    end
endmodule

// File: rtl/ext_route.sv
// Request router.
// Turns a decoded field into memory read/store requests and up to four
// ordered write-request slots. Assumes ptr_cur_i holds the pre-instruction
// pointers and ptr_nxt_i the stepped ones; read data arrives combinationally.
module ext_route
    import ext_pkg::*;
#(
    parameter int PAGE_LSB = 10
)
(
    input  dec_t                   dec_i,
    input  logic                   wide_i,
    input  word_t [PTR_N-1:0]      ptr_cur_i,
    input  word_t [PTR_N-1:0]      ptr_nxt_i,
    input  word_t [ACC_N-1:0]      acc_i,
    input  word_t                  rd_a_data_i,
    input  word_t                  rd_b_data_i,
    output logic                   rd_a_en_o,
    output word_t                  rd_a_addr_o,
    output logic                   rd_b_en_o,
    output word_t                  rd_b_addr_o,
    output logic                   st_en_o,
    output word_t                  st_addr_o,
    output word_t                  st_data_o,
    output logic [SLOT_N-1:0]      slot_vld_o,
    output rid_t [SLOT_N-1:0]      slot_id_o,
    output word_t [SLOT_N-1:0]     slot_dat_o
);
    localparam int unsigned LAST = PTR_N - 1;

    // Build memory requests and the write-request slots
    always_comb begin
        logic [1:0] ld_p;
        logic [1:0] st_p;
        logic       same_page;
        ld_p        = dec_i.swap ? 2'd3 : 2'd0;
        st_p        = dec_i.swap ? 2'd0 : 2'd3;
        same_page   = ptr_cur_i[dec_i.ptr][WORD_W-1:PAGE_LSB] == ptr_cur_i[LAST][WORD_W-1:PAGE_LSB];
        rd_a_en_o   = 1'b0;
        rd_a_addr_o = '0;
        rd_b_en_o   = 1'b0;
        rd_b_addr_o = '0;
        st_en_o     = 1'b0;
        st_addr_o   = '0;
        st_data_o   = '0;
        slot_vld_o  = '0;
        slot_id_o   = '0;
        slot_dat_o  = '0;
        case (dec_i.opc)
            OPC_PTR: begin
                slot_vld_o[0] = 1'b1;
                slot_id_o[0]  = RID_PTR0 + rid_t'(dec_i.ptr);
                slot_dat_o[0] = ptr_nxt_i[dec_i.ptr];
            end
            OPC_MOVE: begin
                slot_vld_o[0] = 1'b1;
                slot_id_o[0]  = rid_t'(dec_i.dst);
                slot_dat_o[0] = acc_i[dec_i.src];
            end
            OPC_STORE: begin
                st_en_o       = 1'b1;
                st_addr_o     = ptr_cur_i[dec_i.ptr];
                st_data_o     = acc_i[dec_i.src];
                slot_vld_o[0] = 1'b1;
                slot_id_o[0]  = RID_PTR0 + rid_t'(dec_i.ptr);
                slot_dat_o[0] = ptr_nxt_i[dec_i.ptr];
            end
            OPC_LOAD: begin
                rd_a_en_o   = 1'b1;
                rd_a_addr_o = ptr_cur_i[dec_i.ptr];
                if (wide_i && dec_i.dst[2:1] == 2'b11) begin
                    slot_vld_o    = 4'b1111;
                    slot_id_o[0]  = RID_HIGH0 + rid_t'(dec_i.dst[0]);
                    slot_dat_o[0] = {WORD_W{rd_a_data_i[WORD_W-1]}};
                    slot_id_o[1]  = rid_t'(dec_i.dst);
                    slot_dat_o[1] = rd_a_data_i;
                    slot_id_o[2]  = RID_LOW0 + rid_t'(dec_i.dst[0]);
                    slot_dat_o[2] = '0;
                    slot_id_o[3]  = RID_PTR0 + rid_t'(dec_i.ptr);
                    slot_dat_o[3] = ptr_nxt_i[dec_i.ptr];
                end else begin
                    slot_vld_o    = 4'b0011;
                    slot_id_o[0]  = rid_t'(dec_i.dst);
                    slot_dat_o[0] = rd_a_data_i;
                    slot_id_o[1]  = RID_PTR0 + rid_t'(dec_i.ptr);
                    slot_dat_o[1] = ptr_nxt_i[dec_i.ptr];
                end
            end
            OPC_PAIR: begin
                rd_a_en_o     = 1'b1;
                rd_a_addr_o   = ptr_cur_i[ld_p];
                st_en_o       = 1'b1;
                st_addr_o     = ptr_cur_i[st_p];
                st_data_o     = acc_i[dec_i.src];
                slot_vld_o    = 4'b0111;
                slot_id_o[0]  = rid_t'(dec_i.dst);
                slot_dat_o[0] = rd_a_data_i;
                slot_id_o[1]  = RID_PTR0 + rid_t'(LAST);
                slot_dat_o[1] = ptr_nxt_i[LAST];
                slot_id_o[2]  = RID_PTR0;
                slot_dat_o[2] = ptr_nxt_i[0];
            end
            OPC_DUAL: begin
                rd_a_en_o     = 1'b1;
                rd_a_addr_o   = ptr_cur_i[dec_i.ptr];
                rd_b_en_o     = 1'b1;
                rd_b_addr_o   = same_page ? ptr_cur_i[dec_i.ptr] : ptr_cur_i[LAST];
                slot_vld_o    = 4'b1111;
                slot_id_o[0]  = dec_i.via3 ? rid_t'({2'b01, dec_i.r_sel}) : rid_t'({dec_i.d_sel, 1'b0});
                slot_dat_o[0] = rd_a_data_i;
                slot_id_o[1]  = dec_i.via3 ? rid_t'(dec_i.r_sel) : rid_t'({dec_i.r_sel, 1'b1});
                slot_dat_o[1] = rd_b_data_i;
                slot_id_o[2]  = RID_PTR0 + rid_t'(dec_i.ptr);
                slot_dat_o[2] = ptr_nxt_i[dec_i.ptr];
                slot_id_o[3]  = RID_PTR0 + rid_t'(LAST);
                slot_dat_o[3] = ptr_nxt_i[LAST];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ext_addr_unit.sv
// Extension-field address unit (top).
// Holds the four address pointers, steps them per instruction and registers
// the ordered write requests for the merge stage. Assumes the data memory
// answers reads in the same cycle and that the merge stage accepts every
// request slot without back-pressure.
module ext_addr_unit
    import ext_pkg::*;
#(
    parameter int                          PAGE_LSB   = 10,
    parameter logic [PTR_N*WORD_W-1:0]     WRAP_MASKS = '1
)
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ins_valid,
    input  logic [CODE_W-1:0]          ins_ext,
    input  logic                       wide_mode,
    input  logic [PTR_N*WORD_W-1:0]    idx_vals,
    input  logic [ACC_N*WORD_W-1:0]    acc_vals,
    output logic                       rd_a_en,
    output logic [WORD_W-1:0]          rd_a_addr,
    input  logic [WORD_W-1:0]          rd_a_data,
    output logic                       rd_b_en,
    output logic [WORD_W-1:0]          rd_b_addr,
    input  logic [WORD_W-1:0]          rd_b_data,
    output logic                       st_en,
    output logic [WORD_W-1:0]          st_addr,
    output logic [WORD_W-1:0]          st_data,
    output logic [SLOT_N-1:0]          wb_vld,
    output logic [SLOT_N*RID_W-1:0]    wb_id,
    output logic [SLOT_N*WORD_W-1:0]   wb_dat,
    output logic [PTR_N*WORD_W-1:0]    ptr_vals
);
    dec_t                  dec;
    step_e [PTR_N-1:0]     step;
    word_t [PTR_N-1:0]     ptr_q;
    word_t [PTR_N-1:0]     ptr_nxt;
    word_t [PTR_N-1:0]     idx_w;
    word_t [ACC_N-1:0]     acc_w;
    logic  [SLOT_N-1:0]    slot_vld;
    rid_t  [SLOT_N-1:0]    slot_id;
    word_t [SLOT_N-1:0]    slot_dat;
    logic  [SLOT_N-1:0]    vld_q;
    rid_t  [SLOT_N-1:0]    id_q;
    word_t [SLOT_N-1:0]    dat_q;

    assign idx_w = idx_vals;
    assign acc_w = acc_vals;

    ext_decode u_dec (
        .valid_i (ins_valid),
        .code_i  (ins_ext),
        .dec_o   (dec),
        .step_o  (step)
    );

    // One stepper per pointer, each with its own wrap mask
    for (genvar g = 0; g < PTR_N; g++) begin : g_step
        ext_step #(
            .MASK (WRAP_MASKS[g*WORD_W +: WORD_W])
        ) u_step (
            .cur_i  (ptr_q[g]),
            .idx_i  (idx_w[g]),
            .kind_i (step[g]),
            .nxt_o  (ptr_nxt[g])
        );
    end

    ext_route #(
        .PAGE_LSB (PAGE_LSB)
    ) u_route (
        .dec_i       (dec),
        .wide_i      (wide_mode),
        .ptr_cur_i   (ptr_q),
        .ptr_nxt_i   (ptr_nxt),
        .acc_i       (acc_w),
        .rd_a_data_i (rd_a_data),
        .rd_b_data_i (rd_b_data),
        .rd_a_en_o   (rd_a_en),
        .rd_a_addr_o (rd_a_addr),
        .rd_b_en_o   (rd_b_en),
        .rd_b_addr_o (rd_b_addr),
        .st_en_o     (st_en),
        .st_addr_o   (st_addr),
        .st_data_o   (st_data),
        .slot_vld_o  (slot_vld),
        .slot_id_o   (slot_id),
        .slot_dat_o  (slot_dat)
    );

    // Pointer state and registered write requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            vld_q <= '0;
            id_q  <= '0;
            dat_q <= '0;
        end else begin
            ptr_q <= ptr_nxt;
            vld_q <= slot_vld;
            id_q  <= slot_id;
            dat_q <= slot_dat;
        end
    end

    assign wb_vld   = vld_q;
    assign wb_id    = id_q;
    assign wb_dat   = dat_q;
    assign ptr_vals = ptr_q;
endmodule

// File: rtl/ext_addr_unit_chk.sv
// Property checker for ext_addr_unit, attached by bind below.
module ext_addr_unit_chk
    import ext_pkg::*;
#(
    parameter int PAGE_LSB = 10
)
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ins_valid,
    input logic                     rd_a_en,
    input logic [WORD_W-1:0]        rd_a_addr,
    input logic                     rd_b_en,
    input logic [WORD_W-1:0]        rd_b_addr,
    input logic                     st_en,
    input logic [SLOT_N-1:0]        wb_vld,
    input logic [PTR_N*WORD_W-1:0]  ptr_vals
);
    // R1: reset clears pointers and requests
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (wb_vld == '0 && ptr_vals == '0));

    // R2: no memory traffic without a valid field
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> (!rd_a_en && !rd_b_en && !st_en));

    // R2: idle cycle leaves pointers alone and yields no requests
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> ($stable(ptr_vals) && wb_vld == '0));

    // R12: request slots are packed from slot 0
    p_slots_packed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_vld & (wb_vld + 1'b1)) == '0);

    // R11: second read never lands in the first read's page at another address
    p_alias_page_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_en |-> (rd_b_addr[WORD_W-1:PAGE_LSB] != rd_a_addr[WORD_W-1:PAGE_LSB]
                     || rd_b_addr == rd_a_addr));

    // R10: second read only comes with a first read
    p_dual_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_en |-> rd_a_en);

    // R9: a store never coincides with a double load
    p_store_single_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> !rd_b_en);
endmodule

bind ext_addr_unit ext_addr_unit_chk #(.PAGE_LSB(PAGE_LSB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .rd_a_en   (rd_a_en),
    .rd_a_addr (rd_a_addr),
    .rd_b_en   (rd_b_en),
    .rd_b_addr (rd_b_addr),
    .st_en     (st_en),
    .wb_vld    (wb_vld),
    .ptr_vals  (ptr_vals)
);

// File: tb/sim_ext_addr_unit.sv
module sim_ext_addr_unit;
    localparam int          PERIOD = 10;
    localparam logic [63:0] MASKS  = {16'hFFFF, 16'h000F, 16'hFFFF, 16'hFFFF};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ins_valid;
    logic [7:0]  ins_ext;
    logic        wide_mode;
    logic [63:0] idx_vals;
    logic [63:0] acc_vals;
    logic        rd_a_en, rd_b_en, st_en;
    logic [15:0] rd_a_addr, rd_b_addr, rd_a_data, rd_b_data, st_addr, st_data;
    logic [3:0]  wb_vld;
    logic [15:0] wb_id;
    logic [63:0] wb_dat;
    logic [63:0] ptr_vals;

    always #(PERIOD/2) clk = ~clk;

    ext_addr_unit #(.PAGE_LSB(10), .WRAP_MASKS(MASKS)) u0 (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ext(ins_ext),
        .wide_mode(wide_mode), .idx_vals(idx_vals), .acc_vals(acc_vals),
        .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .st_en(st_en), .st_addr(st_addr), .st_data(st_data),
        .wb_vld(wb_vld), .wb_id(wb_id), .wb_dat(wb_dat), .ptr_vals(ptr_vals)
    );

    function automatic logic [15:0] memv(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'hA53C ^ (a << 3);
    endfunction

    assign rd_a_data = memv(rd_a_addr);
    assign rd_b_data = memv(rd_b_addr);

    function automatic logic [15:0] wrapped(input int r, input logic [15:0] old, input logic [15:0] delta);
        logic [15:0] m;
        m = MASKS[r*16 +: 16];
        return (old & ~m) | ((old + delta) & m);
    endfunction

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] mar [4];
    logic [15:0] mix [4];
    logic [15:0] macc [4];
    logic [3:0]  e_v;
    logic [15:0] e_id;
    logic [63:0] e_d;
    int          e_n;

    task automatic check(input string tag, input string what, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic add_slot(input logic [3:0] id, input logic [15:0] d);
        e_v[e_n]          = 1'b1;
        e_id[e_n*4 +: 4]  = id;
        e_d[e_n*16 +: 16] = d;
        e_n++;
    endtask

    task automatic do_op(input logic [7:0] code, input logic wide);
        logic        ea_en, eb_en, es_en;
        logic [15:0] ea, eb, esa, esd, dv;
        logic [15:0] nar [4];
        logic [3:0]  id1, id2;
        string       tg, ptg;
        int          p, f, ld, st;
        e_v = '0; e_id = '0; e_d = '0; e_n = 0;
        ea_en = 0; eb_en = 0; es_en = 0; ea = 0; eb = 0; esa = 0; esd = 0;
        for (int i = 0; i < 4; i++) nar[i] = mar[i];
        tg = "R3";
        if (code[7:2] == 6'd0) begin
            tg = "R3";
        end else if (code[7:4] == 4'd0) begin
            p = int'(code[1:0]);
            case (code[3:2])
                2'd1:    nar[p] = wrapped(p, mar[p], 16'hFFFF);
                2'd2:    nar[p] = wrapped(p, mar[p], 16'h0001);
                default: nar[p] = wrapped(p, mar[p], mix[p]);
            endcase
            add_slot(4'(12 + p), nar[p]);
        end else if (code[7:4] == 4'd1) begin
            tg = "R5";
            add_slot({2'b00, code[3:2]}, macc[code[1:0]]);
        end else if (code[7:5] == 3'd1) begin
            tg = "R6";
            p = int'(code[1:0]);
            es_en = 1; esa = mar[p]; esd = macc[code[4:3]];
            nar[p] = wrapped(p, mar[p], code[2] ? mix[p] : 16'h0001);
            add_slot(4'(12 + p), nar[p]);
        end else if (code[7:6] == 2'd1) begin
            p = int'(code[1:0]);
            f = int'(code[5:3]);
            ea_en = 1; ea = mar[p]; dv = memv(mar[p]);
            nar[p] = wrapped(p, mar[p], code[2] ? mix[p] : 16'h0001);
            if (wide && f >= 6) begin
                tg = "R8";
                add_slot(4'(8 + f - 6), dv[15] ? 16'hFFFF : 16'h0000);
                add_slot(4'(f), dv);
                add_slot(4'(4 + f - 6), 16'h0000);
            end else begin
                tg = "R7";
                add_slot(4'(f), dv);
            end
            add_slot(4'(12 + p), nar[p]);
        end else if (code[7:6] == 2'd2) begin
            tg = "R9";
            ld = code[1] ? 3 : 0;
            st = code[1] ? 0 : 3;
            ea_en = 1; ea = mar[ld];
            es_en = 1; esa = mar[st]; esd = macc[2 + int'(code[0])];
            nar[0] = wrapped(0, mar[0], code[2] ? mix[0] : 16'h0001);
            nar[3] = wrapped(3, mar[3], code[3] ? mix[3] : 16'h0001);
            add_slot({2'b00, code[5:4]}, memv(ea));
            add_slot(4'd15, nar[3]);
            add_slot(4'd12, nar[0]);
        end else begin
            tg = "R10";
            p = (code[1:0] != 2'd3) ? int'(code[1:0]) : int'(code[5]);
            ea_en = 1; ea = mar[p]; eb_en = 1;
            if (mar[p][15:10] == mar[3][15:10]) begin
                eb = mar[p];
                tg = "R11";
            end else begin
                eb = mar[3];
            end
            nar[p] = wrapped(p, mar[p], code[2] ? mix[p] : 16'h0001);
            nar[3] = wrapped(3, mar[3], code[3] ? mix[3] : 16'h0001);
            if (code[1:0] != 2'd3) begin
                id1 = code[5] ? 4'd2 : 4'd0;
                id2 = code[4] ? 4'd3 : 4'd1;
            end else begin
                id1 = code[4] ? 4'd3 : 4'd2;
                id2 = code[4] ? 4'd1 : 4'd0;
            end
            add_slot(id1, memv(ea));
            add_slot(id2, memv(eb));
            add_slot(4'(12 + p), nar[p]);
            add_slot(4'd15, nar[3]);
        end
        ptg = (nar[2] != mar[2]) ? "R4" : "R12";

        @(negedge clk);
        // R2: previous cycle was idle
        check("R2", "idle requests", 96'(wb_vld), 96'(0));
        check("R2", "idle enables", 96'({rd_a_en, rd_b_en, st_en}), 96'(0));
        check("R2", "idle pointers", 96'(ptr_vals), 96'({mar[3], mar[2], mar[1], mar[0]}));
        ins_valid = 1'b1;
        ins_ext   = code;
        wide_mode = wide;
        idx_vals  = {mix[3], mix[2], mix[1], mix[0]};
        acc_vals  = {macc[3], macc[2], macc[1], macc[0]};
        #1;
        check(tg, "read a", 96'({rd_a_en, rd_a_addr}), 96'({ea_en, ea}));
        check(tg, "read b", 96'({rd_b_en, rd_b_addr}), 96'({eb_en, eb}));
        check(tg, "store", 96'({st_en, st_addr, st_data}), 96'({es_en, esa, esd}));
        @(negedge clk);
        ins_valid = 1'b0;
        check(tg, "request valids", 96'(wb_vld), 96'(e_v));
        check(tg, "request ids", 96'(wb_id), 96'(e_id));
        check(tg, "request data", 96'(wb_dat), 96'(e_d));
        check(ptg, "pointers", 96'(ptr_vals), 96'({nar[3], nar[2], nar[1], nar[0]}));
        for (int i = 0; i < 4; i++) mar[i] = nar[i];
    endtask

    task automatic set_ptrs(input logic [15:0] t0, input logic [15:0] t1, input logic [15:0] t2, input logic [15:0] t3);
        logic [15:0] tgt [4];
        logic [15:0] saved;
        tgt[0] = t0; tgt[1] = t1; tgt[2] = t2; tgt[3] = t3;
        for (int r = 0; r < 4; r++) begin
            saved  = mix[r];
            mix[r] = tgt[r] - mar[r];
            do_op(8'h0C | 8'(r), 1'b0);
            mix[r] = saved;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; ins_valid = 1'b0; ins_ext = '0; wide_mode = 1'b0;
        idx_vals = '0; acc_vals = '0;
        for (int i = 0; i < 4; i++) begin
            mar[i] = '0; mix[i] = '0; macc[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state after reset
        check("R1", "reset requests", 96'(wb_vld), 96'(0));
        check("R1", "reset pointers", 96'(ptr_vals), 96'(0));
        rst_n = 1'b1;
        for (int s = 0; s < 3; s++) begin
            case (s)
                0: begin
                    mix[0] = 16'h0001; mix[1] = 16'hFFFD; mix[2] = 16'h0007; mix[3] = 16'h0100;
                end
                1: begin
                    mix[0] = 16'h0040; mix[1] = 16'h8000; mix[2] = 16'hFFFF; mix[3] = 16'hFFF0;
                end
                default: begin
                    mix[0] = 16'h0002; mix[1] = 16'h7FFF; mix[2] = 16'h0009; mix[3] = 16'h0003;
                end
            endcase
            macc[0] = 16'h1111 ^ 16'(s * 16'h0F0F);
            macc[1] = 16'h2222 ^ 16'(s * 16'h0F0F);
            macc[2] = 16'h8333 ^ 16'(s * 16'h0F0F);
            macc[3] = 16'h4444 ^ 16'(s * 16'h0F0F);
            for (int w = 0; w < 2; w++) begin
                for (int c = 0; c < 256; c++) begin
                    case (s)
                        0:       set_ptrs(16'h0010, 16'h0123, 16'h0005, 16'h0400);
                        1:       set_ptrs(16'h0C00, 16'h0C10, 16'h000F, 16'h0C3F);
                        default: set_ptrs(16'hFFFF, 16'h8000, 16'h0000, 16'hFFFE);
                    endcase
                    do_op(8'(c), w[0]);
                end
            end
        end
        summary();
        $finish;
    end
endmodule